// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the digital half of an eight-channel, 8-bit successive-approximation converter. It picks the analog channel to sample, steps a DAC code through a most-significant-bit-first binary search against an external comparator, and places each finished code in one of eight result slots. The analog multiplexer, the sample-and-hold, the DAC and the reference sit outside the block.

A conversion takes 26 machine cycles: 8 for sampling, 8 for bit trials, and 10 for settling. A round is eight conversions, one per slot, and lasts 208 machine cycles. In scan mode, slots 0 to 3 take channels 0 to 3. In select mode, one lower channel, chosen by two select bits, is converted four times in a row into slots 0, 1, 2 and 3. Slots 4 to 7 always take channels 4 to 7.

Rounds repeat without a break while the block is enabled, or one round is started by each rising trigger edge. No flag marks the end of a single conversion.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, all eight result slots read 0, `dac_o` is 0 and `ch_o` is 0.
- R2: With `en_i` = 0 the block is idle: no result slot changes and the trigger has no effect. With `en_i` = 1 and `trig_mode_i` = 0, rounds run back to back with no gap.
- R3: With `mode_i` = 0 (scan), slot s holds the code of channel s for s = 0 to 3.
- R4: With `mode_i` = 1 (select), slots 0 to 3 hold four successive conversions of channel `sel_i` (0 to 3), and `ch_o` equals `sel_i` while those four conversions run.
- R5: Slots 4 to 7 hold channels 4 to 7 in either mode, and `ch_o` equals the slot number while they are converted.
- R6: Each conversion lasts 26 machine cycles of `MC_DIV` clocks each. Slot s is written on clock edge E + 26·(s+1)·`MC_DIV`, where E is the edge at which the round starts. No other edge writes it, and at most one slot changes per edge.
- R7: The code is found MSB first. `cmp_i` = 1 means the input is at or above `dac_o`, and the trial bit is then kept. `dac_o` is 0 while sampling. With an ideal comparator the stored code equals the input level.
- R8: With `trig_mode_i` = 1, the edge that samples `trig_i` at 1 after a 0 starts exactly one round. The block then waits, even if `trig_i` stays high.
- R9: `mode_i` and `sel_i` are captured when a round starts. Changing them during the round has no effect on that round.
- R10: Result slot s is visible on `res_o[8s+7:8s]`, and a slot changes only when its whole conversion completes, so a partial code is never seen.
- R11: Dropping `en_i` during a round aborts it without writing the slot being converted. The block returns to idle with `dac_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| mode_i | input | 1 | 0 = scan, 1 = select |
| sel_i | input | 2 | Lower channel converted in select mode |
| trig_mode_i | input | 1 | 1 = one round per rising trigger edge |
| trig_i | input | 1 | External trigger |
| cmp_i | input | 1 | Comparator: input at or above DAC code |
| dac_o | output | RES_W | Trial code for the DAC |
| ch_o | output | 3 | Analog channel select |
| res_o | output | 8·RES_W | Eight result slots, slot s at bits [8s+7:8s] |

## Verification
Every result lands a fixed number of clocks after the round's start edge E: slot s on edge E + 26·(s+1)·`MC_DIV`, and the whole round ends on E + 208·`MC_DIV`. The bench drives the trigger on a falling edge, so E is the next rising edge. For slot 0 it samples on the falling edge just before and just after E + 52 (with `MC_DIV` = 2), and expects the old and then the new code. The channel-select checks fall at falling edges chosen to lie inside slot 1 and at the start of slot 5. Whole-round checks wait 208·`MC_DIV` + 4 clocks, past the last write, before reading the slots.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int N_SLOT = 8;
  localparam int SLOT_W = 3;
  localparam int N_LOW  = 4;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/mc_tick_gen.sv
module mc_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == W'(DIV - 1));
  assign tick_o = run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || last)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_MC = 26,
  localparam int PH_W   = $clog2(CONV_MC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [1:0]        sel_i,
  input  logic              trig_mode_i,
  input  logic              trig_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] ch_o,
  output logic              done_o,
  output logic              mode_o,
  output logic [1:0]        sel_o
);
  seq_state_e        state_q;
  logic              trig_q, rise, go, last_ph, conv_end;
  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic              mode_q;
  logic [1:0]        sel_q;

  assign rise     = trig_i && !trig_q;
  assign go       = en_i && (!trig_mode_i || rise);
  assign last_ph  = (phase_q == PH_W'(CONV_MC - 1));
  assign conv_end = (state_q == ST_RUN) && tick_i && last_ph;
  assign done_o   = conv_end && en_i;
  assign run_o    = (state_q == ST_RUN);
  assign phase_o  = phase_q;
  assign slot_o   = slot_q;
  assign mode_o   = mode_q;
  assign sel_o    = sel_q;

  always_comb begin
    if (int'(slot_q) < N_LOW && mode_q) ch_o = {1'b0, sel_q};
    else                                ch_o = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
      phase_q <= '0;
      slot_q  <= '0;
      mode_q  <= 1'b0;
      sel_q   <= '0;
    end else begin
      trig_q <= trig_i;
      if (state_q == ST_IDLE) begin
        phase_q <= '0;
        slot_q  <= '0;
        if (go) begin
          state_q <= ST_RUN;
          mode_q  <= mode_i;
          sel_q   <= sel_i;
        end
      end else if (!en_i) begin
        state_q <= ST_IDLE;   // abort, current slot not written
        phase_q <= '0;
        slot_q  <= '0;
      end else if (tick_i) begin
        if (last_ph) begin
          phase_q <= '0;
          if (slot_q == SLOT_W'(N_SLOT - 1)) begin
            slot_q <= '0;
            if (trig_mode_i) state_q <= ST_IDLE;
            else begin
              mode_q <= mode_i;
              sel_q  <= sel_i;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W     = 8,
  parameter int SAMPLE_MC = 8,
  parameter int PH_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] code_o
);
  logic [RES_W-1:0] acc_q, mask;
  logic             trial;

  always_comb begin
    trial = 1'b0;
    mask  = '0;
    if (int'(phase_i) >= SAMPLE_MC && int'(phase_i) < SAMPLE_MC + RES_W) begin
      trial = 1'b1;
      mask  = RES_W'(1) << (SAMPLE_MC + RES_W - 1 - int'(phase_i));
    end
  end

  assign dac_o  = acc_q | mask;
  assign code_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       acc_q <= '0;
    else if (clr_i)                    acc_q <= '0;
    else if (tick_i && trial && cmp_i) acc_q <= acc_q | mask;
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [RES_W-1:0]        data_i,
  output logic [N_SLOT*RES_W-1:0] res_o
);
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             r_q <= '0;
      else if (we_i && slot_i == SLOT_W'(s))   r_q <= data_i;
    end
    assign res_o[s*RES_W +: RES_W] = r_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int MC_DIV    = 12,
  parameter int SAMPLE_MC = 8,
  parameter int SETTLE_MC = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    mode_i,
  input  logic [1:0]              sel_i,
  input  logic                    trig_mode_i,
  input  logic                    trig_i,
  input  logic                    cmp_i,
  output logic [RES_W-1:0]        dac_o,
  output logic [SLOT_W-1:0]       ch_o,
  output logic [N_SLOT*RES_W-1:0] res_o
);
  localparam int CONV_MC = SAMPLE_MC + RES_W + SETTLE_MC;
  localparam int PH_W    = $clog2(CONV_MC);

  logic              run, tick, done, mode_q;
  logic [1:0]        sel_q;
  logic [PH_W-1:0]   phase;
  logic [SLOT_W-1:0] slot;
  logic [RES_W-1:0]  code;

  mc_tick_gen #(.DIV(MC_DIV)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick)
  );

  adc_seq_ctrl #(.CONV_MC(CONV_MC)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .mode_i, .sel_i, .trig_mode_i, .trig_i,
    .tick_i(tick), .run_o(run), .phase_o(phase), .slot_o(slot),
    .ch_o, .done_o(done), .mode_o(mode_q), .sel_o(sel_q)
  );

  adc_sar_core #(.RES_W(RES_W), .SAMPLE_MC(SAMPLE_MC), .PH_W(PH_W)) u_sar (
    .clk_i, .rst_ni, .clr_i(!run || done), .tick_i(tick),
    .phase_i(phase), .cmp_i, .dac_o, .code_o(code)
  );

  adc_result_bank #(.RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni, .we_i(done), .slot_i(slot), .data_i(code), .res_o
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int SAMPLE_MC = 8,
  parameter int CONV_MC   = 26,
  parameter int PH_W      = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    run,
  input logic                    tick,
  input logic                    mode_q,
  input logic [1:0]              sel_q,
  input logic [PH_W-1:0]         phase,
  input logic [SLOT_W-1:0]       slot,
  input logic [SLOT_W-1:0]       ch_o,
  input logic [RES_W-1:0]        dac_o,
  input logic [N_SLOT*RES_W-1:0] res_o
);
  logic [N_SLOT*RES_W-1:0] res_d;
  logic [N_SLOT-1:0]       chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_d <= '0;
    else         res_d <= res_o;
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_chg
    assign chg[s] = (res_o[s*RES_W +: RES_W] != res_d[s*RES_W +: RES_W]);
  end

  AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(res_o));                                                 // R2
  AST_SAMPLE_DAC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && int'(phase) < SAMPLE_MC) |-> dac_o == '0);                         // R7
  AST_WRITE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> $past(tick && phase == PH_W'(CONV_MC - 1)));           // R6
  AST_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);                                                     // R6
  AST_PHASE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase) < CONV_MC);                                                    // R6
  AST_UPPER_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && int'(slot) >= N_LOW) |-> ch_o == slot);                            // R5
  AST_SEL_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode_q && int'(slot) < N_LOW) |-> ch_o == {1'b0, sel_q});          // R4
endmodule

bind adc_scan_seq adc_seq_chk #(
  .RES_W(RES_W), .SAMPLE_MC(SAMPLE_MC), .CONV_MC(CONV_MC), .PH_W(PH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run(run), .tick(tick),
  .mode_q(mode_q), .sel_q(sel_q), .phase(phase), .slot(slot),
  .ch_o(ch_o), .dac_o(dac_o), .res_o(res_o)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int D     = 2;
  localparam int ROUND = 208 * D;

  typedef struct packed {
    logic        mode;
    logic [1:0]  sel;
    logic [63:0] ain;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 2'd0, 64'hFF807F010055AAC3},
    '{1'b1, 2'd2, 64'h123456789ABCDEF0},
    '{1'b1, 2'd0, 64'h0F1E2D3C4B5A69FF},
    '{1'b1, 2'd3, 64'h8001FE7F40201008}
  };

  logic        clk = 0, rst_ni = 0;
  logic        en = 0, mode = 0, trig_mode = 1, trig = 0;
  logic [1:0]  sel = 0;
  logic [63:0] ain = '0;
  logic [7:0]  dac;
  logic [2:0]  ch;
  logic [63:0] res;
  logic        cmp;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign cmp = (ain[ch*8 +: 8] >= dac);

  adc_scan_seq #(.MC_DIV(D)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode), .sel_i(sel),
    .trig_mode_i(trig_mode), .trig_i(trig), .cmp_i(cmp),
    .dac_o(dac), .ch_o(ch), .res_o(res)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_slot(input logic [63:0] a, input logic m,
                                          input logic [1:0] s, input int k);
    if (k < 4 && m) return a[s*8 +: 8];
    return a[k*8 +: 8];
  endfunction

  task automatic pulse_round();
    @(negedge clk) trig = 1;
    repeat (2) @(negedge clk);
    trig = 0;
    repeat (ROUND + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] snap;
    logic [63:0] exp_all;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res", res, '0);
    check("R1 dac", {56'd0, dac}, '0);
    check("R1 ch", {61'd0, ch}, '0);
    rst_ni = 1;

    // R2 disabled: trigger and free-run ignored
    ain = 64'h1111111111111111;
    pulse_round();
    trig_mode = 0;
    repeat (ROUND) @(negedge clk);
    check("R2 idle res", res, '0);
    check("R2 idle dac", {56'd0, dac}, '0);
    trig_mode = 1;
    en = 1;

    // table walk: R3 R4 R5 R7
    foreach (VECS[i]) begin
      ain = VECS[i].ain; mode = VECS[i].mode; sel = VECS[i].sel;
      pulse_round();
      for (int k = 0; k < 8; k++)
        check(k >= 4 ? "R5 upper slot" : (mode ? "R4 select slot" : "R3 scan slot"),
              {56'd0, res[k*8 +: 8]}, {56'd0, exp_slot(ain, mode, sel, k)});
    end

    // R6 timing, R4/R5 channel select, R8 held trigger
    snap = res;
    ain = 64'hA1B2C3D4E5F60718; mode = 1; sel = 3;
    @(negedge clk) trig = 1;
    repeat (26 * D) @(posedge clk);
    @(negedge clk);
    check("R6 slot0 before end", {56'd0, res[7:0]}, {56'd0, snap[7:0]});
    @(negedge clk);
    check("R6 slot0 at end", {56'd0, res[7:0]}, {56'd0, ain[31:24]});
    check("R6 slot1 untouched", {56'd0, res[15:8]}, {56'd0, snap[15:8]});
    check("R4 ch in slot1", {61'd0, ch}, 64'd3);
    repeat (104 * D) @(negedge clk);
    check("R5 ch in slot5", {61'd0, ch}, 64'd5);
    repeat (ROUND) @(negedge clk);
    snap = res;
    ain = ~ain;
    repeat (ROUND + 20) @(negedge clk);
    check("R8 no restart on held trigger", res, snap);
    trig = 0;

    // R9 mode captured at round start
    ain = 64'h0102030405060708; mode = 0; sel = 0;
    @(negedge clk) trig = 1;
    repeat (10) @(negedge clk);
    trig = 0; mode = 1; sel = 1;
    repeat (ROUND) @(negedge clk);
    exp_all = ain;
    check("R9 scan kept", res, exp_all);

    // R10/R11 abort mid-conversion
    snap = res;
    ain = 64'hEEEEEEEEEEEEEEEE; mode = 0;
    @(negedge clk) trig = 1;
    repeat (20) @(negedge clk);
    trig = 0; en = 0;
    repeat (200) @(negedge clk);
    check("R11 abort no write", res, snap);
    check("R11 abort dac", {56'd0, dac}, '0);

    // R2 continuous rounds
    en = 1; trig_mode = 0; mode = 0;
    ain = 64'h5A5A5A5A5A5A5A5A;
    repeat (ROUND + 10) @(negedge clk);
    check("R2 free-run slot7", {56'd0, res[63:56]}, 64'h5A);
    ain = 64'h00FF00FF00FF00FF;
    repeat (2 * ROUND + 10) @(negedge clk);
    check("R2 free-run refresh R10", res, ain);
    en = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule